// File: doc/BRIEF.md
# Two-Digit Synchronous Decimal Counter

This block counts from 00 to 99 and keeps the value as two 4-bit decimal digits, ones and tens. Both digits are registered on one shared clock. A count-enable input decides whether the value moves on a given edge. A synchronous active-high clear returns both digits to zero.

Each digit stage recognises its last value, nine, from only two of its bits: the most significant bit and the least significant bit. On the next edge it loads zeros in place of an increment. The tens stage moves only in a cycle where the ones stage already holds nine. A terminal-count output tells a downstream stage that the next enabled edge will roll 99 over to 00, so further counters can be chained from it.

Internally, a control module turns the enable and the per-digit last-value flags into a small struct of step and load strobes. The datapath module holds the digit registers and acts on those strobes.

Top module: `bcd_pair_counter`

## Requirements
- R1: Each digit output only ever carries the codes 0000 to 1001, standing for the values 0 to 9.
- R2: When clear is high at a rising edge, both digits become 0000 after that edge, whatever countEn and the current value are.
- R3: When countEn is low at a rising edge and clear is low, neither digit changes. This holds even while the ones digit is nine.
- R4: With countEn high and the ones digit below nine, the ones digit rises by exactly one at the edge.
- R5: With countEn high and the ones digit at nine (bit 3 and bit 0 both 1), the ones digit is loaded with 0000 at the edge.
- R6: The tens digit advances by one only at an edge where countEn is high and the ones digit is nine. At every other edge it holds.
- R7: When countEn is high and both digits are nine, the edge takes the value from 99 to 00.
- R8: termCount is combinational and is high exactly when countEn is high and both digits are nine.
- R9: After a clear, the value read as tens*10 + ones always equals the number of enabled edges since that clear, modulo 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by every digit register |
| clear | input | 1 | Synchronous active-high clear to 00 |
| countEn | input | 1 | Count enable; gates both digit stages |
| onesDigit | output | 4 | Low decimal digit, codes 0000 to 1001 |
| tensDigit | output | 4 | High decimal digit, codes 0000 to 1001 |
| termCount | output | 1 | High when countEn is set and the value is 99 |

## Verification
Two pairs of actions can fall on the same edge. The first pair is the ones wrap and the tens advance, which happen together on every x9 to (x+1)0 step and on the full 99 to 00 rollover. The second pair is a clear and a pending carry. The bench first counts up to 99. It then applies one enabled edge and expects 00 with termCount high just before that edge. Next it returns to 99 and raises clear while countEn is still high. There it expects 00 with no stray tens increment. An independent modulo-100 integer model, checked on every edge of a long run with irregular enable gaps, judges that clear always wins and that the tens digit never moves without the ones digit at nine.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

  // width of one decimal digit field
  localparam int DIGIT_W    = 4;
  // number of cascaded decimal stages
  localparam int NUM_DIGITS = 2;
  // last legal value of a stage
  localparam int DIGIT_LAST = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic                  clr;   // synchronous clear of every stage
    logic [NUM_DIGITS-1:0] step;  // stage is enabled this edge
    logic [NUM_DIGITS-1:0] load;  // stage loads zeros instead of incrementing
  } digitStrobe_t;

endpackage

// File: rtl/bcd_cnt_ctrl.sv
module bcd_cnt_ctrl
  import bcd_cnt_pkg::*;
(
  input  logic                  clk,
  input  logic                  clear,
  input  logic                  countEn,
  input  logic [NUM_DIGITS-1:0] lastFlag,
  output digitStrobe_t          strobe,
  output logic                  termCount
);

  // carryChain[i] is high when stage i is allowed to move this edge
  logic [NUM_DIGITS:0] carryChain;

  assign carryChain[0] = countEn;

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_chain
    assign carryChain[gi+1] = carryChain[gi] & lastFlag[gi];
    assign strobe.step[gi]  = carryChain[gi];
    assign strobe.load[gi]  = carryChain[gi] & lastFlag[gi];
  end

  assign strobe.clr = clear;
  assign termCount  = carryChain[NUM_DIGITS];

  // R8
  term_needs_enable_chk: assert property (@(posedge clk) disable iff (clear)
    termCount |-> countEn);

endmodule

// File: rtl/bcd_cnt_datapath.sv
module bcd_cnt_datapath
  import bcd_cnt_pkg::*;
(
  input  logic                               clk,
  input  digitStrobe_t                       strobe,
  output logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digitQ,
  output logic [NUM_DIGITS-1:0]              lastFlag
);

  for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_stage
    // two-bit detect of the last value: MSB and LSB together only occur at nine
    assign lastFlag[gi] = digitQ[gi][DIGIT_W-1] & digitQ[gi][0];

    always_ff @(posedge clk) begin
      if (strobe.clr)
        digitQ[gi] <= '0;
      else if (strobe.load[gi])
        digitQ[gi] <= '0;
      else if (strobe.step[gi])
        digitQ[gi] <= digitQ[gi] + 1'b1;
    end

    // R1
    digit_range_chk: assert property (@(posedge clk) disable iff (strobe.clr)
      digitQ[gi] <= digit_t'(DIGIT_LAST));

    // R4
    digit_step_chk: assert property (@(posedge clk) disable iff (strobe.clr)
      (strobe.step[gi] && !lastFlag[gi]) |=> digitQ[gi] == digit_t'($past(digitQ[gi]) + 1'b1));

    // R5
    digit_wrap_chk: assert property (@(posedge clk) disable iff (strobe.clr)
      (strobe.step[gi] && lastFlag[gi]) |=> digitQ[gi] == '0);

    // R6
    digit_hold_chk: assert property (@(posedge clk) disable iff (strobe.clr)
      !strobe.step[gi] |=> $stable(digitQ[gi]));
  end

endmodule

// File: rtl/bcd_pair_counter.sv
module bcd_pair_counter
  import bcd_cnt_pkg::*;
(
  input  logic               clk,
  input  logic               clear,
  input  logic               countEn,
  output logic [DIGIT_W-1:0] onesDigit,
  output logic [DIGIT_W-1:0] tensDigit,
  output logic               termCount
);

  digitStrobe_t                       strobe;
  logic [NUM_DIGITS-1:0][DIGIT_W-1:0] digitQ;
  logic [NUM_DIGITS-1:0]              lastFlag;

  bcd_cnt_ctrl u_ctrl (
    .clk       (clk),
    .clear     (clear),
    .countEn   (countEn),
    .lastFlag  (lastFlag),
    .strobe    (strobe),
    .termCount (termCount)
  );

  bcd_cnt_datapath u_path (
    .clk      (clk),
    .strobe   (strobe),
    .digitQ   (digitQ),
    .lastFlag (lastFlag)
  );

  assign onesDigit = digitQ[0];
  assign tensDigit = digitQ[1];

  // R2
  clear_zero_chk: assert property (@(posedge clk)
    clear |=> (onesDigit == '0 && tensDigit == '0));

  // R3
  enable_hold_chk: assert property (@(posedge clk) disable iff (clear)
    !countEn |=> ($stable(onesDigit) && $stable(tensDigit)));

  // R7
  rollover_chk: assert property (@(posedge clk) disable iff (clear)
    termCount |=> (onesDigit == '0 && tensDigit == '0));

endmodule

// File: tb/bcd_pair_counter_test.sv
`timescale 1ns/1ps
module bcd_pair_counter_test;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       countEn = 1'b0;
  logic [3:0] onesDigit;
  logic [3:0] tensDigit;
  logic       termCount;

  int checks = 0;
  int errors = 0;
  int refCount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcd_pair_counter uut (
    .clk       (clk),
    .clear     (clear),
    .countEn   (countEn),
    .onesDigit (onesDigit),
    .tensDigit (tensDigit),
    .termCount (termCount)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one edge: drive at negedge, check termCount before the edge, digits after
  task automatic tick(input logic en, input logic clr);
    @(negedge clk);
    countEn = en;
    clear   = clr;
    #1;
    // R8: combinational terminal count
    chk("R8 termCount", int'(termCount), int'(en && !clr && refCount == 99) |
        int'(en && clr && refCount == 99));
    @(posedge clk);
    if (clr) refCount = 0;
    else if (en) refCount = (refCount + 1) % 100;
    #1;
  endtask

  task automatic checkValue(input string req);
    chk(req, int'(tensDigit) * 10 + int'(onesDigit), refCount);
    // R1: code range
    chk("R1 ones range", int'(onesDigit <= 4'd9), 1);
    chk("R1 tens range", int'(tensDigit <= 4'd9), 1);
  endtask

  task automatic testReset();
    tick(1'b1, 1'b1);
    chk("R2 reset ones", int'(onesDigit), 0);
    chk("R2 reset tens", int'(tensDigit), 0);
  endtask

  task automatic testCountUp();
    tick(1'b0, 1'b1);
    for (int i = 0; i < 25; i++) begin
      logic [3:0] prevOnes = onesDigit;
      logic [3:0] prevTens = tensDigit;
      tick(1'b1, 1'b0);
      if (prevOnes == 4'd9) begin
        chk("R5 ones load zero", int'(onesDigit), 0);
        chk("R6 tens carry", int'(tensDigit), int'(prevTens) + 1);
      end else begin
        chk("R4 ones step", int'(onesDigit), int'(prevOnes) + 1);
        chk("R6 tens hold", int'(tensDigit), int'(prevTens));
      end
      checkValue("R9 value");
    end
  endtask

  task automatic testHoldAtNine();
    tick(1'b0, 1'b1);
    for (int i = 0; i < 9; i++) tick(1'b1, 1'b0);
    chk("R3 setup ones nine", int'(onesDigit), 9);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0);
      chk("R3 ones held at nine", int'(onesDigit), 9);
      chk("R3 tens held", int'(tensDigit), 0);
    end
    tick(1'b1, 1'b0);
    chk("R6 carry after gap", int'(tensDigit), 1);
    chk("R5 ones wrap after gap", int'(onesDigit), 0);
  endtask

  task automatic testRollover();
    tick(1'b0, 1'b1);
    for (int i = 0; i < 99; i++) tick(1'b1, 1'b0);
    chk("R7 at 99 ones", int'(onesDigit), 9);
    chk("R7 at 99 tens", int'(tensDigit), 9);
    @(negedge clk);
    countEn = 1'b0;
    #1;
    chk("R8 termCount low without enable", int'(termCount), 0);
    tick(1'b1, 1'b0);
    chk("R7 rollover ones", int'(onesDigit), 0);
    chk("R7 rollover tens", int'(tensDigit), 0);
  endtask

  task automatic testClearPriority();
    tick(1'b0, 1'b1);
    for (int i = 0; i < 99; i++) tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    chk("R2 clear beats carry ones", int'(onesDigit), 0);
    chk("R2 clear beats carry tens", int'(tensDigit), 0);
    for (int i = 0; i < 19; i++) tick(1'b1, 1'b0);
    tick(1'b1, 1'b1);
    chk("R2 clear at 19 ones", int'(onesDigit), 0);
    chk("R2 clear at 19 tens", int'(tensDigit), 0);
  endtask

  task automatic testRandomRun();
    logic [15:0] lfsr = 16'hACE1;
    int enabled = 0;
    tick(1'b0, 1'b1);
    while (enabled < 300) begin
      logic en;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      en = (lfsr[2:0] != 3'b000);
      if (en) enabled++;
      tick(en, 1'b0);
      checkValue("R9 random run");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    testReset();
    testCountUp();
    testHoldAtNine();
    testRollover();
    testClearPriority();
    testRandomRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule